// File: doc/BRIEF.md
# Serial Baud Rate Generator

This block times one serial channel. An 8-bit divider register, which software can write and read at any time, sets a reload value N. A 2-bit clock-select input picks a power-of-four prescaler step: 1, 4, 16 or 64 peripheral clock cycles. The prescaler and the reload divider together produce one internal pulse every step × (N+1) cycles. A post-scaler then turns these pulses into the channel's timing outputs, and the mode input decides how. In asynchronous mode it issues a 16x oversampling tick and a bit tick. In synchronous mode it issues a bit tick and a serial clock level with four internal pulses per bit.

Every output is a single-cycle enable or a registered level in the peripheral clock domain, and no derived clocks exist. The block carries no data stream, so it has no valid/ready handshake. The register port is a plain one-cycle write strobe with a continuously driven read value. A register write, a change of clock select or a change of mode clears all counters, so the new timing starts from a known phase. Each instance holds its own register and counters. A multi-channel design places one instance per channel.

Top module: `baud_gen`

## Requirements
- R1: After reset the divider register reads 0xFF, and it changes only on a write.
- R2: A write with `wr_en` high loads `wr_data`, and `rd_data` shows the new value from the next cycle onward.
- R3: `clk_sel` selects the prescaler step: value 0 gives 1 cycle, 1 gives 4, 2 gives 16 and 3 gives 64 (step = 4^clk_sel).
- R4: With `sync_mode` = 0 (asynchronous), `bit_tick` pulses once every 32 × 4^clk_sel × (N+1) cycles.
- R5: In asynchronous mode `os_tick` pulses every 2 × 4^clk_sel × (N+1) cycles. There are exactly 16 pulses per bit period, and the 16th falls in the same cycle as `bit_tick`.
- R6: With `sync_mode` = 1 (synchronous), `bit_tick` pulses once every 4 × 4^clk_sel × (N+1) cycles, and `os_tick` stays low.
- R7: In synchronous mode `sclk` is low for the first half of each bit period and high for the second half, so it is high in the cycle of `bit_tick`. In asynchronous mode it stays low.
- R8: After a register write, the first `bit_tick` is high in exactly the P-th cycle after the write edge, where P is the new bit period. This holds even when the write lands in the middle of a period.
- R9: A change of `clk_sel` or `sync_mode` with no write also restarts the counters. The first `bit_tick` then comes exactly one new period after the change is seen.
- R10: `bit_tick` and `os_tick` are single-cycle pulses and are never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Divider register write strobe |
| wr_data | input | DIV_W | Value written to the divider register |
| rd_data | output | DIV_W | Current divider register value |
| clk_sel | input | CS_W | Prescaler step select (4^clk_sel cycles) |
| sync_mode | input | 1 | 0 asynchronous, 1 synchronous |
| os_tick | output | 1 | 16x oversampling enable (asynchronous only) |
| bit_tick | output | 1 | One pulse per bit period |
| sclk | output | 1 | Serial clock level (synchronous only) |

## Verification
The bench builds the block with its default parameters: an 8-bit divider, a 2-bit select and power-of-four steps. All four prescaler steps in both modes can therefore be measured against the formulas. Small divider values keep the longest selection (step 64, asynchronous) within a few thousand cycles. The reset value 0xFF is measured only with the undivided step, where a full bit period is 8192 cycles.

// File: rtl/brg_pkg.sv
package brg_pkg;
  typedef enum logic {
    BRG_ASYNC = 1'b0,
    BRG_SYNC  = 1'b1
  } brg_mode_e;

  // Post-scaler exponents: pulses per bit = 2^x
  localparam int BRG_ASYNC_LOG2 = 5;  // 32 divider pulses per async bit
  localparam int BRG_SYNC_LOG2  = 2;  // 4 divider pulses per sync bit
  localparam int BRG_OS_LOG2    = 1;  // 2 divider pulses per oversample tick
  localparam int BRG_STEP_LOG2  = 2;  // prescaler grows by 4 per select code
endpackage

// File: rtl/brg_prescale.sv
module brg_prescale #(
  parameter int CS_W      = 2,
  parameter int STEP_LOG2 = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic [CS_W-1:0] sel,
  output logic            step_en
);
  localparam int PRE_W = STEP_LOG2 * ((1 << CS_W) - 1);

  logic [PRE_W-1:0] cnt;
  logic [PRE_W-1:0] mask;

  // Low bits that must all be ones before an enable is issued
  always_comb begin
    for (int i = 0; i < PRE_W; i++) begin
      mask[i] = (i < STEP_LOG2 * int'(sel));
    end
  end

  assign step_en = &(cnt | ~mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/brg_divider.sv
module brg_divider #(
  parameter int             W       = 8,
  parameter logic [W-1:0]   RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic [W-1:0] start_val,
  input  logic [W-1:0] reload_val,
  input  logic         step_en,
  output logic         pulse
);
  logic [W-1:0] cnt;

  assign pulse = step_en && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= RST_VAL;
    else if (restart) cnt <= start_val;
    else if (step_en) cnt <= (cnt == '0) ? reload_val : cnt - 1'b1;
  end
endmodule

// File: rtl/brg_postscale.sv
module brg_postscale #(
  parameter int A_LOG2  = 5,
  parameter int S_LOG2  = 2,
  parameter int OS_LOG2 = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic sync_sel,
  input  logic pulse,
  output logic os_tick,
  output logic bit_tick,
  output logic sclk
);
  localparam int              PH_W      = A_LOG2;
  localparam logic [PH_W-1:0] SYNC_LAST = PH_W'((1 << S_LOG2) - 1);
  localparam logic [PH_W-1:0] ASYN_LAST = '1;

  logic [PH_W-1:0] phase;
  logic [PH_W-1:0] last;

  assign last     = sync_sel ? SYNC_LAST : ASYN_LAST;
  assign bit_tick = pulse && (phase == last);
  assign os_tick  = !sync_sel && pulse && (&phase[OS_LOG2-1:0]);
  assign sclk     = sync_sel && phase[S_LOG2-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase <= '0;
    else if (restart) phase <= '0;
    else if (pulse)   phase <= (phase == last) ? '0 : phase + 1'b1;
  end
endmodule

// File: rtl/baud_gen.sv
module baud_gen
  import brg_pkg::*;
#(
  parameter int               DIV_W   = 8,
  parameter int               CS_W    = 2,
  parameter logic [DIV_W-1:0] RST_DIV = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [DIV_W-1:0] wr_data,
  output logic [DIV_W-1:0] rd_data,
  input  logic [CS_W-1:0]  clk_sel,
  input  logic             sync_mode,
  output logic             os_tick,
  output logic             bit_tick,
  output logic             sclk
);
  logic [DIV_W-1:0] div_q;
  logic [CS_W-1:0]  cs_q;
  brg_mode_e        mode_q;
  brg_mode_e        mode_in;
  logic             restart;
  logic [DIV_W-1:0] start_val;
  logic             step_en;
  logic             div_pulse;

  assign mode_in   = brg_mode_e'(sync_mode);
  assign restart   = wr_en || (clk_sel != cs_q) || (mode_in != mode_q);
  assign start_val = wr_en ? wr_data : div_q;
  assign rd_data   = div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= RST_DIV;
      cs_q   <= '0;
      mode_q <= BRG_ASYNC;
    end else begin
      if (wr_en) div_q <= wr_data;
      cs_q   <= clk_sel;
      mode_q <= mode_in;
    end
  end

  brg_prescale #(
    .CS_W      (CS_W),
    .STEP_LOG2 (BRG_STEP_LOG2)
  ) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .sel     (clk_sel),
    .step_en (step_en)
  );

  brg_divider #(
    .W       (DIV_W),
    .RST_VAL (RST_DIV)
  ) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (restart),
    .start_val  (start_val),
    .reload_val (div_q),
    .step_en    (step_en),
    .pulse      (div_pulse)
  );

  brg_postscale #(
    .A_LOG2  (BRG_ASYNC_LOG2),
    .S_LOG2  (BRG_SYNC_LOG2),
    .OS_LOG2 (BRG_OS_LOG2)
  ) u_post (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .sync_sel (mode_in == BRG_SYNC),
    .pulse    (div_pulse),
    .os_tick  (os_tick),
    .bit_tick (bit_tick),
    .sclk     (sclk)
  );
endmodule

// File: rtl/brg_checker.sv
module brg_checker #(
  parameter int DIV_W = 8,
  parameter int CS_W  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [DIV_W-1:0] wr_data,
  input logic [DIV_W-1:0] rd_data,
  input logic [CS_W-1:0]  clk_sel,
  input logic             sync_mode,
  input logic             os_tick,
  input logic             bit_tick,
  input logic             sclk
);
  logic [CS_W-1:0] cs_seen;
  logic            mode_seen;
  logic [4:0]      os_cnt;
  logic            restart_now;

  assign restart_now = wr_en || (clk_sel != cs_seen) || (sync_mode != mode_seen);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_seen   <= '0;
      mode_seen <= 1'b0;
      os_cnt    <= '0;
    end else begin
      cs_seen   <= clk_sel;
      mode_seen <= sync_mode;
      if (restart_now || bit_tick) os_cnt <= '0;
      else if (os_tick)            os_cnt <= os_cnt + 1'b1;
    end
  end

  p_rdback_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data == $past(wr_data)));

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data));

  p_os16_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && !sync_mode && !restart_now) |-> (os_cnt == 5'd15));

  p_os_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && !sync_mode) |-> os_tick);

  p_sync_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && mode_seen) |-> !os_tick);

  p_sclk_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && sync_mode && !restart_now) |-> sclk);

  p_bit_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> !bit_tick);

  p_os_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    os_tick |=> !os_tick);
endmodule

bind baud_gen brg_checker #(
  .DIV_W (DIV_W),
  .CS_W  (CS_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .rd_data   (rd_data),
  .clk_sel   (clk_sel),
  .sync_mode (sync_mode),
  .os_tick   (os_tick),
  .bit_tick  (bit_tick),
  .sclk      (sclk)
);

// File: tb/baud_gen_bench.sv
`timescale 1ns/1ps
module baud_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [1:0] clk_sel = '0;
  logic       sync_mode = 1'b0;
  logic       os_tick, bit_tick, sclk;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  baud_gen u_baud_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .clk_sel(clk_sel), .sync_mode(sync_mode),
    .os_tick(os_tick), .bit_tick(bit_tick), .sclk(sclk)
  );

  // {sync_mode, clk_sel, N, expected bit period}
  localparam int NV = 10;
  localparam logic [30:0] VEC [NV] = '{
    {1'b0, 2'd0, 8'd0, 20'd32},
    {1'b0, 2'd0, 8'd2, 20'd96},
    {1'b0, 2'd1, 8'd1, 20'd256},
    {1'b0, 2'd2, 8'd0, 20'd512},
    {1'b0, 2'd3, 8'd1, 20'd4096},
    {1'b1, 2'd0, 8'd0, 20'd4},
    {1'b1, 2'd0, 8'd5, 20'd24},
    {1'b1, 2'd1, 8'd2, 20'd48},
    {1'b1, 2'd2, 8'd1, 20'd128},
    {1'b1, 2'd3, 8'd0, 20'd256}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Counts cycles up to and including the next bit_tick, plus os/sclk activity
  task automatic wait_tick(output int cyc, output int os_n, output int sclk_n);
    cyc = 0; os_n = 0; sclk_n = 0;
    forever begin
      @(negedge clk);
      cyc++;
      os_n   += int'(os_tick);
      sclk_n += int'(sclk);
      if (bit_tick || cyc > 20000) break;
    end
  endtask

  task automatic write_div(input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    int cyc, os_n, sc_n;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset value", int'(rd_data), 255);

    // R4 at reset value: async, step 1, N=255 -> 8192
    wait_tick(cyc, os_n, sc_n);
    wait_tick(cyc, os_n, sc_n);
    check("R4 reset-value period", cyc, 8192);
    check("R5 os ticks per bit", os_n, 16);

    // Vector table: R3/R4/R5/R6/R7/R8
    for (int i = 0; i < NV; i++) begin
      logic       m;
      logic [1:0] cs;
      logic [7:0] n;
      int         p;
      m  = VEC[i][30];
      cs = VEC[i][29:28];
      n  = VEC[i][27:20];
      p  = int'(VEC[i][19:0]);
      @(negedge clk);
      sync_mode = m; clk_sel = cs; wr_en = 1'b1; wr_data = n;
      @(posedge clk);
      #1 wr_en = 1'b0;
      wait_tick(cyc, os_n, sc_n);
      check("R8 first tick after write", cyc, p);
      wait_tick(cyc, os_n, sc_n);
      check(m ? "R6 sync period (R3 step)" : "R4 async period (R3 step)", cyc, p);
      if (m) begin
        check("R6 no os_tick in sync", os_n, 0);
        check("R7 sclk high half", sc_n, p / 2);
      end else begin
        check("R5 os ticks per bit", os_n, 16);
        check("R7 sclk low in async", sc_n, 0);
      end
      check("R2 readback", int'(rd_data), int'(n));
    end

    // R8: mid-period rewrite restarts the full period
    @(negedge clk);
    sync_mode = 1'b0; clk_sel = 2'd0;
    write_div(8'd3);
    repeat (50) @(negedge clk);
    write_div(8'd3);
    wait_tick(cyc, os_n, sc_n);
    check("R8 mid-period restart", cyc, 128);

    // R9: clock-select change alone restarts
    write_div(8'd1);
    wait_tick(cyc, os_n, sc_n);
    repeat (10) @(negedge clk);
    clk_sel = 2'd1;
    @(posedge clk);
    wait_tick(cyc, os_n, sc_n);
    check("R9 restart on clk_sel", cyc, 256);
    check("R1 held without write", int'(rd_data), 1);

    // R9: mode change alone restarts
    repeat (7) @(negedge clk);
    sync_mode = 1'b1;
    @(posedge clk);
    wait_tick(cyc, os_n, sc_n);
    check("R9 restart on mode", cyc, 32);

    // R10: fastest setting, ticks must not stretch
    @(negedge clk);
    clk_sel = 2'd0;
    write_div(8'd0);
    begin
      int dbl = 0;
      logic prev = 1'b0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (bit_tick && prev) dbl++;
        prev = bit_tick;
      end
      check("R10 bit_tick single cycle", dbl, 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule